// File: doc/BRIEF.md
# Display Data Channel Control and Status Register

This block holds the four control and status bits of a display data channel serial port. A CPU writes and reads them through a single-register interface. The bits are a sticky flag that catches falling edges on the active clock pin, a mode bit, an address-match status bit and a pre-buffer enable bit. The mode bit chooses between normal two-wire bus operation and the transmit-only DDC1 mode. The same bit selects which pin supplies the clock: the bus clock pin or the vertical-sync clock pin. It also gates the edge interrupt.

The serial shifter, the address comparator and the pre-buffer storage sit outside this block. They report to it through single-cycle strobes: address matched, start seen, stop seen. The block sends back the clock-pin select and the edge interrupt request. It also tells the shifter whether to stretch the clock line low when the port raises an interrupt. That hold is suppressed in DDC1 mode, and it is also suppressed in slave mode while the pre-buffers are enabled.

Top module: `ddc_ctl`

## Requirements
- R1: After reset the register reads 0x08: the pre-buffer enable (bit 3) is 1, bits 2, 1 and 0 are 0, and `clk_sel_o` is 0.
- R2: A falling edge on the selected clock pin sets the edge flag (bit 0) within three rising clock edges. Edges on the pin that is not selected leave the flag unchanged.
- R3: Writing 0 to bit 0 clears the edge flag and writing 1 to bit 0 leaves it unchanged. When a detected edge and a clearing write occur in the same cycle, the flag ends up set.
- R4: Bit 1 is read/write. `clk_sel_o` equals bit 1: 0 selects `bus_scl_i` and 1 selects `ddc1_clk_i`. `edge_irq_o` equals bit 0 AND bit 1.
- R5: A pulse on `addr_hit_i` sets bit 2. A pulse on `bus_start_i` or `bus_stop_i` clears it, and a start or stop wins over a match in the same cycle. CPU writes never change bit 2.
- R6: Bit 3 is read/write. Writing 1 enables the pre-buffers and writing 0 disables them.
- R7: Bits above bit 3 always read as 0, and writing them has no effect.
- R8: `scl_hold_o` is 1 exactly when `port_irq_i` is 1, bit 1 is 0, and bit 3 and `slave_mode_i` are not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe for the register |
| wr_data_i | input | DATA_W | CPU write data |
| rd_data_o | output | DATA_W | Register read value |
| bus_scl_i | input | 1 | Two-wire bus clock pin level |
| ddc1_clk_i | input | 1 | Vertical-sync clock pin level |
| addr_hit_i | input | 1 | Received address matched the slave address (strobe) |
| bus_start_i | input | 1 | Bus start condition detected (strobe) |
| bus_stop_i | input | 1 | Bus stop condition detected (strobe) |
| port_irq_i | input | 1 | Serial port interrupt is being raised |
| slave_mode_i | input | 1 | Port is currently operating as slave |
| clk_sel_o | output | 1 | Selected clock pin: 0 bus clock, 1 vertical-sync clock |
| edge_irq_o | output | 1 | Falling-edge interrupt request |
| scl_hold_o | output | 1 | Hold the clock line low for the pending interrupt |

## Verification
A stuck or mis-set mode bit shows at once on `clk_sel_o` and on the register read. It also shows as a wrong `scl_hold_o` in the same cycle that `port_irq_i` rises. A fault in the synchronizer or the edge detector shows as the edge flag still missing on the fourth cycle after a pin falls, or as the flag being set by the unselected pin. Faults in the flag priority logic appear on the read one cycle after the colliding strobes: a clear that beats a set, or a match that survives a start. The hold output is swept over all sixteen combinations of its four inputs.

// File: rtl/ddc_ctl_pkg.sv
package ddc_ctl_pkg;
  localparam int CTL_W = 4;

  // bit order is the register layout: [3]=pbuf_en .. [0]=edge_flag
  typedef struct packed {
    logic pbuf_en;
    logic addr_hit;
    logic ddc1_mode;
    logic edge_flag;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{pbuf_en: 1'b1, addr_hit: 1'b0, ddc1_mode: 1'b0, edge_flag: 1'b0};
endpackage

// File: rtl/ddc_ctl_edge.sv
module ddc_ctl_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_a_i,
  input  logic pin_b_i,
  input  logic sel_b_i,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   pin_sel;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  assign pin_sel = sel_b_i ? pin_b_i : pin_a_i;

  // idle-high reset so a released line gives no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      if (SYNC_STAGES > 1) sync_q <= {sync_q[SYNC_STAGES-2:0], pin_sel};
      else                 sync_q <= pin_sel;
      prev_q <= sync_q[LAST];
    end
  end

  assign fall_o = prev_q & ~sync_q[LAST];

  // R2
  fall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ddc_ctl_regs.sv
module ddc_ctl_regs
  import ddc_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             fall_i,
  input  logic             hit_i,
  input  logic             start_i,
  input  logic             stop_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q, ctl_d;
  ctl_t wr;

  assign wr = ctl_t'(wdata_i);

  always_comb begin
    ctl_d = ctl_q;
    if (we_i) begin
      ctl_d.ddc1_mode = wr.ddc1_mode;
      ctl_d.pbuf_en   = wr.pbuf_en;
      if (!wr.edge_flag) ctl_d.edge_flag = 1'b0;
    end
    if (fall_i) ctl_d.edge_flag = 1'b1;         // hardware set beats clear
    if (hit_i) ctl_d.addr_hit = 1'b1;
    if (start_i || stop_i) ctl_d.addr_hit = 1'b0;  // frame boundary beats match
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RESET;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  // R2
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> ctl_q.edge_flag);
  // R3
  edge_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.edge_flag && !(we_i && !wdata_i[0])) |=> ctl_q.edge_flag);
  // R5
  hit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !ctl_q.addr_hit);
  // R5
  hit_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.addr_hit) |-> $past(hit_i));
  // R6
  pbuf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_q.pbuf_en));
endmodule

// File: rtl/ddc_ctl_hold.sv
module ddc_ctl_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic slave_i,
  input  logic ddc1_mode_i,
  input  logic pbuf_en_i,
  output logic hold_o
);
  logic suppress;

  assign suppress = ddc1_mode_i | (pbuf_en_i & slave_i);
  assign hold_o   = irq_i & ~suppress;

  // R8
  hold_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (irq_i && !ddc1_mode_i));
endmodule

// File: rtl/ddc_ctl.sv
module ddc_ctl
  import ddc_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              bus_scl_i,
  input  logic              ddc1_clk_i,
  input  logic              addr_hit_i,
  input  logic              bus_start_i,
  input  logic              bus_stop_i,
  input  logic              port_irq_i,
  input  logic              slave_mode_i,
  output logic              clk_sel_o,
  output logic              edge_irq_o,
  output logic              scl_hold_o
);
  ctl_t ctl;
  logic fall;

  ddc_ctl_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_a_i (bus_scl_i),
    .pin_b_i (ddc1_clk_i),
    .sel_b_i (ctl.ddc1_mode),
    .fall_o  (fall)
  );

  ddc_ctl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .wdata_i (wr_data_i[CTL_W-1:0]),
    .fall_i  (fall),
    .hit_i   (addr_hit_i),
    .start_i (bus_start_i),
    .stop_i  (bus_stop_i),
    .ctl_o   (ctl)
  );

  ddc_ctl_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (port_irq_i),
    .slave_i     (slave_mode_i),
    .ddc1_mode_i (ctl.ddc1_mode),
    .pbuf_en_i   (ctl.pbuf_en),
    .hold_o      (scl_hold_o)
  );

  generate
    if (DATA_W > CTL_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:CTL_W];
      assign rd_data_o = {{(DATA_W-CTL_W){1'b0}}, ctl};
    end else begin : g_nopad
      assign rd_data_o = ctl;
    end
  endgenerate

  assign clk_sel_o  = ctl.ddc1_mode;
  assign edge_irq_o = ctl.edge_flag & ctl.ddc1_mode;

  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_irq_o |-> (clk_sel_o && rd_data_o[0]));
  // R7
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o >> CTL_W) == '0);
endmodule

// File: tb/ddc_ctl_bench.sv
module ddc_ctl_bench;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [DW-1:0] wd = '0, rd;
  logic scl = 1'b1, vclk = 1'b1;
  logic hit = 1'b0, start = 1'b0, stop = 1'b0, irq = 1'b0, slave = 1'b0;
  logic clk_sel, edge_irq, hold;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ddc_ctl u_ddc_ctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd),
    .bus_scl_i(scl), .ddc1_clk_i(vclk), .addr_hit_i(hit), .bus_start_i(start),
    .bus_stop_i(stop), .port_irq_i(irq), .slave_mode_i(slave),
    .clk_sel_o(clk_sel), .edge_irq_o(edge_irq), .scl_hold_o(hold)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    settle(2); rst_n = 1'b1; settle(1);
    // R1
    chk("R1 reset value", rd, 8'h08);
    chk("R1 clk_sel", {7'd0, clk_sel}, 8'h00);

    // R7 upper bits ignored, R5 bit2 not writable, R3 write-1 no effect
    wr(8'hFE);
    chk("R7 upper ignored", rd, 8'h0A);
    chk("R4 clk_sel ddc1", {7'd0, clk_sel}, 8'h01);

    // R2 edge on vsync clock in ddc1 mode
    @(negedge clk); vclk = 1'b0; settle(3);
    chk("R2 ddc1 edge", rd, 8'h0B);
    chk("R4 edge_irq on", {7'd0, edge_irq}, 8'h01);
    vclk = 1'b1; settle(3);
    wr(8'h0B);
    chk("R3 write1 keeps", rd, 8'h0B);
    wr(8'h08);
    chk("R3 write0 clears", rd, 8'h08);
    chk("R4 clk_sel normal", {7'd0, clk_sel}, 8'h00);

    // R2 unselected pin ignored
    @(negedge clk); vclk = 1'b0; settle(4);
    chk("R2 unselected pin", rd, 8'h08);
    vclk = 1'b1; settle(3);

    @(negedge clk); scl = 1'b0; settle(3);
    chk("R2 bus edge", rd, 8'h09);
    chk("R4 edge_irq gated", {7'd0, edge_irq}, 8'h00);
    scl = 1'b1; settle(3);
    wr(8'h08);
    chk("R3 clear again", rd, 8'h08);

    // R3 same-cycle set and clear
    @(negedge clk); scl = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; wd = 8'h08;
    @(negedge clk); we = 1'b0;
    chk("R3 set wins", rd, 8'h09);
    scl = 1'b1; settle(3);
    wr(8'h08);

    // R5 address hit
    @(negedge clk); hit = 1'b1; @(negedge clk); hit = 1'b0;
    chk("R5 hit set", rd, 8'h0C);
    wr(8'h08);
    chk("R5 write ignored", rd, 8'h0C);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R5 start clears", rd, 8'h08);
    @(negedge clk); hit = 1'b1; @(negedge clk); hit = 1'b0;
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R5 stop clears", rd, 8'h08);
    @(negedge clk); hit = 1'b1; start = 1'b1; @(negedge clk); hit = 1'b0; start = 1'b0;
    chk("R5 start beats hit", rd, 8'h08);

    // R6 pre-buffer enable
    wr(8'h00);
    chk("R6 pbuf off", rd, 8'h00);
    wr(8'h08);
    chk("R6 pbuf on", rd, 8'h08);

    // R8 exhaustive hold sweep
    for (int m = 0; m < 4; m++) begin
      wr({4'd0, m[1], 2'b00, m[0]} << 0 == 0 ? 8'h00 : {4'd0, m[1], 1'b0, m[0], 1'b0});
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); irq = s[0]; slave = s[1];
        #1;
        chk("R8 hold", {7'd0, hold},
            {7'd0, s[0] & ~m[0] & ~(m[1] & s[1])});
      end
    end
    irq = 1'b0; slave = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule